// File: doc/BRIEF.md
# Stereo Automatic Level Limiter

This block limits the level of a stereo sample stream. On each sample strobe it takes the magnitude of the left and the right sample. If either one reaches a programmable ceiling, it raises a shared attenuation index by a chosen number of 0.375 dB steps. The gain stage that applies the attenuation sits downstream and reads the two per-channel indices this block drives. Recovery, meaning a later reduction of the attenuation, is not handled here.

There are two ways to apply a new attenuation. In zero-cross mode, each channel takes the new shared value at its own next zero crossing. A timeout counted in sample strobes makes sure a channel without a crossing still takes the value. In immediate mode, both indices move together on the strobe that exceeds the ceiling, and the step is always one. A path flag reports whether the limiter serves the recording path or the playback path. The flag depends on which converters are powered.

Top module: `stereo_level_limiter`

## Requirements
- R1: After reset, both gain indices and the shared target are 0, and no channel has a change pending.
- R2: path_rec equals adc_pwr: it is 1 when the ADC is powered, with or without the DAC, and 0 when only the DAC is powered. When neither converter is powered, a strobe changes nothing.
- R3: A strobe is over the ceiling when either channel's magnitude is at or above the level picked by thr_sel: 00 = 24573, 01 = 20437, 10 = 16423, 11 = 12314. The sample -32768 counts as magnitude 32767.
- R4: In zero-cross mode (zc_off = 0), an over-ceiling strobe that arrives while no channel is pending raises the shared target by 1, 2, 4 or 8 for step_sel 00, 01, 10, 11, and marks both channels pending. While any channel is pending, no new raise happens.
- R5: A pending channel takes the target on a later strobe where that channel crosses zero. A crossing is a sample equal to 0, or a sign bit that differs from the channel's previous strobed sample. The previous sample is 0 after reset.
- R6: A channel still pending on the Nth strobe after the raise takes the target on that strobe. N is 128, 256, 512 or 1024 for tmo_sel 00, 01, 10, 11.
- R7: In immediate mode (zc_off = 1), an over-ceiling strobe raises the target and both gain indices by exactly 1 at that strobe's clock edge, whatever step_sel holds. After every strobe, both indices equal the target.
- R8: A strobe below the ceiling changes no index. Raising repeats on every later over-ceiling strobe.
- R9: The target and the gain indices saturate at 127 and never wrap.
- R10: With lim_en = 0, no strobe changes any index, and the indices keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe, one cycle per sample period |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| lim_en | input | 1 | Limiter enable |
| thr_sel | input | 2 | Ceiling select |
| step_sel | input | 2 | Steps per raise in zero-cross mode |
| zc_off | input | 1 | 1 = immediate mode, 0 = zero-cross mode |
| tmo_sel | input | 2 | Timeout select in strobes |
| adc_pwr | input | 1 | ADC powered |
| dac_pwr | input | 1 | DAC powered |
| gain_left | output | 7 | Left attenuation index, 0.375 dB per count |
| gain_right | output | 7 | Right attenuation index, 0.375 dB per count |
| path_rec | output | 1 | 1 = recording path, 0 = playback path |

## Verification
Every index change lands on the rising edge that captures the strobe, so the effect of a strobe is visible one cycle after it is applied. The bench raises the strobe at a falling edge, holds it for exactly one cycle, and compares both indices at the following falling edge. It does this after every strobe, so a change that comes a strobe early or late shows up as a mismatch. Adoption through a crossing or the timeout belongs to a later strobe than the raise, so that strobe's own edge is where the bench expects it. The path flag is combinational and is compared half a cycle after the power inputs settle.

// File: rtl/sll_pkg.sv
package sll_pkg;

   typedef logic [1:0] sel2_t;

   // Steps per raise: forced to one in immediate mode.
   function automatic int unsigned step_count(input sel2_t sel, input logic imm);
      return imm ? 1 : (1 << sel);
   endfunction

   // Strobes until forced adoption.
   function automatic int unsigned tmo_limit(input int unsigned base, input sel2_t sel);
      return base << sel;
   endfunction

endpackage

// File: rtl/sll_chan.sv
module sll_chan #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [DATA_W-1:0] sample,
   output logic [DATA_W-2:0] mag,
   output logic              zc
);
   localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-2:0] MAG_MAX  = {(DATA_W-1){1'b1}};

   logic              prev_sign_q;
   logic [DATA_W-1:0] negated;

   always_comb begin
      negated = -sample;
      if (!sample[DATA_W-1])
         mag = sample[DATA_W-2:0];
      else if (sample == MOST_NEG)
         mag = MAG_MAX;
      else
         mag = negated[DATA_W-2:0];
      zc = (sample == '0) || (sample[DATA_W-1] != prev_sign_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_sign_q <= 1'b0;
      else if (strobe)
         prev_sign_q <= sample[DATA_W-1];
   end
endmodule

// File: rtl/sll_timeout.sv
module sll_timeout
   import sll_pkg::*;
#(
   parameter int TMO_BASE = 128
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clear,
   input  logic  tick,
   input  sel2_t sel,
   output logic  expire
);
   localparam int CNT_W = $clog2(TMO_BASE * 8) + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   always_comb begin
      last   = CNT_W'(tmo_limit(TMO_BASE, sel) - 1);
      expire = tick && (cnt_q == last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/stereo_level_limiter.sv
module stereo_level_limiter
   import sll_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int GAIN_W   = 7,
   parameter int TMO_BASE = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_left,
   input  logic [DATA_W-1:0] smp_right,
   input  logic              lim_en,
   input  logic [1:0]        thr_sel,
   input  logic [1:0]        step_sel,
   input  logic              zc_off,
   input  logic [1:0]        tmo_sel,
   input  logic              adc_pwr,
   input  logic              dac_pwr,
   output logic [GAIN_W-1:0] gain_left,
   output logic [GAIN_W-1:0] gain_right,
   output logic              path_rec
);
   localparam int NCH = 2;
   localparam int SH  = DATA_W - 16;
   localparam logic [GAIN_W:0]   GMAX = {1'b0, {GAIN_W{1'b1}}};
   localparam logic [DATA_W-2:0] C0   = (DATA_W-1)'(24573) << SH;
   localparam logic [DATA_W-2:0] C1   = (DATA_W-1)'(20437) << SH;
   localparam logic [DATA_W-2:0] C2   = (DATA_W-1)'(16423) << SH;
   localparam logic [DATA_W-2:0] C3   = (DATA_W-1)'(12314) << SH;

   if (DATA_W < 16) begin : g_bad_data_w
      $error("stereo_level_limiter: DATA_W must be at least 16");
   end
   if (GAIN_W < 4) begin : g_bad_gain_w
      $error("stereo_level_limiter: GAIN_W must hold an 8-step raise");
   end
   if (TMO_BASE < 1) begin : g_bad_tmo
      $error("stereo_level_limiter: TMO_BASE must be positive");
   end

   logic [DATA_W-1:0] smp_arr [NCH];
   logic [DATA_W-2:0] mag     [NCH];
   logic [NCH-1:0]    zc;
   logic [GAIN_W-1:0] gain_q  [NCH];
   logic [GAIN_W-1:0] tgt_q;
   logic [NCH-1:0]    pend_q;
   logic [DATA_W-2:0] ceiling;
   logic              active, over, fire, tick, expire;
   logic [GAIN_W:0]   sum;
   logic [GAIN_W-1:0] next_tgt;

   assign smp_arr[0] = smp_left;
   assign smp_arr[1] = smp_right;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      sll_chan #(.DATA_W(DATA_W)) i_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .strobe (smp_valid),
         .sample (smp_arr[c]),
         .mag    (mag[c]),
         .zc     (zc[c])
      );
   end

   always_comb begin
      unique case (thr_sel)
         2'd0:    ceiling = C0;
         2'd1:    ceiling = C1;
         2'd2:    ceiling = C2;
         default: ceiling = C3;
      endcase
      active   = lim_en && (adc_pwr || dac_pwr);
      over     = (mag[0] >= ceiling) || (mag[1] >= ceiling);
      sum      = {1'b0, tgt_q} + (GAIN_W+1)'(step_count(step_sel, zc_off));
      next_tgt = (sum > GMAX) ? GMAX[GAIN_W-1:0] : sum[GAIN_W-1:0];
      fire     = smp_valid && active && !zc_off && (pend_q == '0) && over;
      tick     = smp_valid && active && !zc_off && (pend_q != '0);
   end

   sll_timeout #(.TMO_BASE(TMO_BASE)) i_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (fire),
      .tick   (tick),
      .sel    (tmo_sel),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q  <= '0;
         pend_q <= '0;
         for (int c = 0; c < NCH; c++) gain_q[c] <= '0;
      end else if (smp_valid && active) begin
         if (zc_off) begin
            // immediate mode: step forced to one, both channels follow
            tgt_q  <= over ? next_tgt : tgt_q;
            pend_q <= '0;
            for (int c = 0; c < NCH; c++) gain_q[c] <= over ? next_tgt : tgt_q;
         end else if (pend_q == '0) begin
            if (over) begin
               tgt_q  <= next_tgt;
               pend_q <= '1;
            end
         end else begin
            for (int c = 0; c < NCH; c++) begin
               if (pend_q[c] && (zc[c] || expire)) begin
                  gain_q[c] <= tgt_q;
                  pend_q[c] <= 1'b0;
               end
            end
         end
      end
   end

   assign gain_left  = gain_q[0];
   assign gain_right = gain_q[1];
   assign path_rec   = adc_pwr;
endmodule

// File: rtl/sll_checker.sv
module sll_checker #(
   parameter int GAIN_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic              lim_en,
   input logic              zc_off,
   input logic              adc_pwr,
   input logic              dac_pwr,
   input logic [GAIN_W-1:0] gain_left,
   input logic [GAIN_W-1:0] gain_right
);
   logic active;
   assign active = lim_en && (adc_pwr || dac_pwr);

   // R10: a disabled limiter keeps both indices
   a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !lim_en |=> ($stable(gain_left) && $stable(gain_right)));

   // R8: indices move only on a strobe
   a_r8_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(gain_left) && $stable(gain_right)));

   // R9: attenuation never wraps back down
   a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_left >= $past(gain_left)) && (gain_right >= $past(gain_right)));

   // R4: one raise at most per adoption, so a jump stays within eight steps
   a_r4_max_jump: assert property (@(posedge clk) disable iff (!rst_n)
      ((gain_left - $past(gain_left)) <= GAIN_W'(8)) && ((gain_right - $past(gain_right)) <= GAIN_W'(8)));

   // R7: immediate mode keeps both channels equal
   a_r7_channels_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (zc_off && smp_valid && active) |=> (gain_left == gain_right));
endmodule

bind stereo_level_limiter sll_checker #(.GAIN_W(GAIN_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_valid  (smp_valid),
   .lim_en     (lim_en),
   .zc_off     (zc_off),
   .adc_pwr    (adc_pwr),
   .dac_pwr    (dac_pwr),
   .gain_left  (gain_left),
   .gain_right (gain_right)
);

// File: tb/test_stereo_level_limiter.sv
module test_stereo_level_limiter;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              smp_valid = 1'b0;
   logic signed [15:0] smp_left = '0, smp_right = '0;
   logic              lim_en = 1'b0;
   logic [1:0]        thr_sel = '0, step_sel = '0, tmo_sel = '0;
   logic              zc_off = 1'b0;
   logic              adc_pwr = 1'b1, dac_pwr = 1'b0;
   logic [6:0]        gain_left, gain_right;
   logic              path_rec;

   int checks = 0;
   int failures = 0;

   // reference state
   int m_t, m_gl, m_gr, m_cnt;
   bit m_pl, m_pr;
   logic signed [15:0] m_pvl, m_pvr;

   always #10 clk = ~clk;

   stereo_level_limiter i_stereo_level_limiter (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_left(smp_left), .smp_right(smp_right), .lim_en(lim_en),
      .thr_sel(thr_sel), .step_sel(step_sel), .zc_off(zc_off), .tmo_sel(tmo_sel),
      .adc_pwr(adc_pwr), .dac_pwr(dac_pwr),
      .gain_left(gain_left), .gain_right(gain_right), .path_rec(path_rec));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int ceil_of(input logic [1:0] s);
      case (s)
         2'd0: return 24573;
         2'd1: return 20437;
         2'd2: return 16423;
         default: return 12314;
      endcase
   endfunction

   function automatic int mag_of(input logic signed [15:0] x);
      if (x == -16'sd32768) return 32767;
      return (x < 0) ? -int'(x) : int'(x);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_t = 0; m_gl = 0; m_gr = 0; m_cnt = 0; m_pl = 0; m_pr = 0;
      m_pvl = '0; m_pvr = '0;
   endtask

   task automatic smp(input logic signed [15:0] l, input logic signed [15:0] r, input string tag);
      bit act, zl, zr, ov, ex;
      @(negedge clk);
      smp_left = l; smp_right = r; smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      act = lim_en && (adc_pwr || dac_pwr);
      zl  = (l == 0) || (l[15] != m_pvl[15]);
      zr  = (r == 0) || (r[15] != m_pvr[15]);
      ov  = (mag_of(l) >= ceil_of(thr_sel)) || (mag_of(r) >= ceil_of(thr_sel));
      if (act) begin
         if (zc_off) begin
            if (ov) m_t = (m_t + 1 > 127) ? 127 : m_t + 1;
            m_gl = m_t; m_gr = m_t; m_pl = 0; m_pr = 0;
         end else if (!m_pl && !m_pr) begin
            if (ov) begin
               m_t = m_t + (1 << step_sel);
               if (m_t > 127) m_t = 127;
               m_pl = 1; m_pr = 1; m_cnt = 0;
            end
         end else begin
            ex = (m_cnt == (128 << tmo_sel) - 1);
            if (m_pl && (zl || ex)) begin m_gl = m_t; m_pl = 0; end
            if (m_pr && (zr || ex)) begin m_gr = m_t; m_pr = 0; end
            m_cnt++;
         end
      end
      m_pvl = l; m_pvr = r;
      check({tag, " left"}, gain_left, m_gl);
      check({tag, " right"}, gain_right, m_gr);
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      // R1: reset state
      check("R1 reset left", gain_left, 0);
      check("R1 reset right", gain_right, 0);
      lim_en = 1'b1; zc_off = 1'b1; step_sel = 2'd3;

      // R2: path flag for every power combination
      for (int p = 0; p < 4; p++) begin
         @(negedge clk);
         adc_pwr = p[0]; dac_pwr = p[1];
         #1 check("R2 path flag", path_rec, p[0]);
         smp(16'sd30000, 16'sd30000, "R2 power gating");
      end
      adc_pwr = 1'b1; dac_pwr = 1'b1;

      // R3, R7, R8: ceiling sweep in immediate mode, step forced to one
      for (int s = 0; s < 4; s++) begin
         thr_sel = 2'(s);
         smp(16'(ceil_of(2'(s)) - 1), 16'sd5, "R8 below ceiling");
         smp(16'(ceil_of(2'(s))), 16'sd5, "R3 at ceiling left");
         smp(16'sd5, 16'(-ceil_of(2'(s))), "R3 negative right");
         smp(16'sd5, 16'(1 - ceil_of(2'(s))), "R8 just below negative");
         smp(16'(ceil_of(2'(s)) + 100), 16'sd0, "R7 repeat raise");
      end
      thr_sel = 2'd0;
      smp(-16'sd32768, 16'sd0, "R3 most negative");

      // R10: enable low holds everything
      lim_en = 1'b0;
      for (int k = 0; k < 4; k++) smp(16'sd32767, -16'sd32768, "R10 disabled");
      lim_en = 1'b1;

      // R4, R5: zero-cross mode step sweep, per-channel adoption
      do_reset();
      zc_off = 1'b0; tmo_sel = 2'd3;
      for (int s = 0; s < 4; s++) begin
         step_sel = 2'(s);
         smp(16'sd30000, 16'sd30000, "R4 raise holds gains");
         smp(16'sd30000, 16'sd30000, "R4 no raise while pending");
         smp(-16'sd5, 16'sd7, "R5 left crossing");
         smp(-16'sd9, 16'sd0, "R5 right zero sample");
         smp(16'sd3, -16'sd3, "R5 both settled");
      end

      // R6: timeout sweep without crossings
      step_sel = 2'd0;
      for (int t = 0; t < 4; t++) begin
         tmo_sel = 2'(t);
         smp(16'sd30000, 16'sd30000, "R6 raise");
         for (int n = 0; n < (128 << t) + 2; n++) smp(16'sd100, 16'sd100, "R6 timeout");
      end

      // R9: saturation in both modes
      step_sel = 2'd3;
      for (int k = 0; k < 14; k++) begin
         smp(16'sd30000, 16'sd30000, "R9 zc raise");
         smp(-16'sd30000, -16'sd30000, "R9 zc adopt");
      end
      zc_off = 1'b1;
      for (int k = 0; k < 5; k++) smp(16'sd32000, 16'sd32000, "R9 immediate at max");
      check("R9 saturated", gain_left, 127);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule